// File: doc/BRIEF.md
# One-Time-Programmable Array Write Sequencer

This block walks a host-chosen address window of a one-time-programmable memory and burns each byte into the array. Every programming pulse is a fixed one-millisecond write strobe at raised voltage. After each pulse, the byte is read back while the raised voltage is still applied. A byte that reads back wrong gets another pulse, up to a bounded number of attempts. A byte that reads back right moves the walk to the next address.

Once the whole window is burnt, the raised voltage is dropped. Every byte is then read again at nominal supply and compared with the host's source data. Only a clean second pass counts as success. If the host asked for it, the block then applies a single read-protection write at a fixed protection address.

The host provides the window and an optional lock request with a one-cycle start. It serves source bytes through a combinational lookup port indexed by the sequencer. It waits for done, which comes with exactly one of pass or fail.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held and after it is released, with no start seen, busy, done, pass, fail, the write strobe, the read strobe and the high-voltage enable are all 0.
- R2: A start while idle or done latches the first address, the last address and the lock request, and raises busy on the next cycle. A start while busy has no effect on the addresses that are programmed or on the outcome.
- R3: Every programming pulse holds the write strobe high for exactly CLK_HZ/1000 consecutive cycles. During a pulse the high-voltage enable is 1, the register/memory select is 0 and read/write is 0 (write).
- R4: Addresses are programmed in ascending order from first to last inclusive. After each pulse the byte is read with the high-voltage enable at 1, select at 0 and read/write at 1. A match moves to the next address with the attempt count cleared. A mismatch issues another pulse at the same address.
- R5: If the byte still mismatches after the MAX_TRIES-th pulse (10 by default), the run ends with fail. No further pulse is issued and later addresses are left untouched. A byte that matches on exactly the MAX_TRIES-th pulse is accepted.
- R6: After the last address verifies, every address of the window is read again with the high-voltage enable at 0 and read/write at 1. Any byte that differs from the source data ends the run with fail.
- R7: When every byte of the second pass matches, the run ends with pass.
- R8: If lock was requested and the second pass matched, one pulse is issued before pass, at address PROT_ADDR (0E3Fh), with select 1, high-voltage enable 1 and read/write 0. Without a lock request, or after a fail, no such pulse occurs.
- R9: Pass and fail are never both 1. Done, pass and fail hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| first_addr_i | input | AW | First address of the window |
| last_addr_i | input | AW | Last address of the window (not below the first) |
| lock_i | input | 1 | Request a read-protection write after a clean run |
| src_addr_o | output | AW | Address of the source byte wanted from the host |
| src_data_i | input | DW | Source byte for src_addr_o, combinational |
| arr_addr_o | output | AW | Array address |
| arr_wdata_o | output | DW | Array write data |
| arr_rdata_i | input | DW | Array read data, combinational on arr_addr_o |
| arr_wr_o | output | 1 | Programming write strobe |
| arr_rd_o | output | 1 | Array read strobe |
| hv_en_o | output | 1 | Programming-voltage enable |
| regsel_o | output | 1 | Register/memory select (1 = protection register) |
| rw_o | output | 1 | Read/write select (1 = read, 0 = write) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has ended |
| pass_o | output | 1 | The run ended with success |
| fail_o | output | 1 | The run ended with failure |

## Verification
A wrong attempt count shows up at the array port within one pulse. The number of strobes seen at an address differs from the number the array model needs, or a run fails or passes where the limit says otherwise. A wrong pulse-length counter shows on the very first strobe as a wrong high time. A wrong address walker shows as strobes outside the window or missing inside it; a wrong mode encoding shows as a voltage or read/write level that disagrees with the strobe in the same cycle. A broken second pass shows only at the end of the run: an array byte that is corrupted at nominal supply still yields pass, or the protection write appears after a fail.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE  = 3'd1,
    ST_VERIFY = 3'd2,
    ST_CMP    = 3'd3,
    ST_LOCK   = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_t;

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int CYC = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last_o = run_i && (cnt_q == CW'(CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || last_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PULSE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CYC)); // R3
  AST_PULSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0); // R3
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int TW = $clog2(MAX + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign limit_o = (cnt_q == TW'(MAX));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (inc_i && !limit_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX)); // R5
endmodule

// File: rtl/otp_addr_walk.sv
module otp_addr_walk #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          step_i,
  input  logic          rewind_i,
  input  logic          active_i,
  output logic [AW-1:0] cur_o,
  output logic          at_last_o
);
  logic [AW-1:0] first_q, last_q, cur_q;
  logic [AW-1:0] first_d, last_d, cur_d;

  assign cur_o     = cur_q;
  assign at_last_o = (cur_q == last_q);

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    cur_d   = cur_q;
    if (load_i) begin
      first_d = first_i;
      last_d  = last_i;
      cur_d   = first_i;
    end else if (rewind_i) begin
      cur_d   = first_q;
    end else if (step_i) begin
      cur_d   = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      cur_q   <= '0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      cur_q   <= cur_d;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cur_q >= first_q) && (cur_q <= last_q)); // R4
  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && !load_i |=> $stable(first_q) && $stable(last_q)); // R2
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int            AW        = 14,
  parameter int            DW        = 8,
  parameter int            CLK_HZ    = 12_000_000,
  parameter int            MAX_TRIES = 10,
  parameter logic [AW-1:0] PROT_ADDR = AW'('h0E3F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic          lock_i,
  output logic [AW-1:0] src_addr_o,
  input  logic [DW-1:0] src_data_i,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_wdata_o,
  input  logic [DW-1:0] arr_rdata_i,
  output logic          arr_wr_o,
  output logic          arr_rd_o,
  output logic          hv_en_o,
  output logic          regsel_o,
  output logic          rw_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o
);
  localparam int PULSE_CYC = CLK_HZ / 1000;

  seq_state_t    state_q, state_d;
  logic          lock_q, lock_d;
  logic          pass_q, pass_d;
  logic          fail_q, fail_d;

  logic          timer_run, timer_last;
  logic          try_clr, try_inc, try_limit;
  logic          walk_load, walk_step, walk_rewind, walk_at_last;
  logic [AW-1:0] cur_addr;
  logic          byte_ok;
  logic          accept;

  assign byte_ok = (arr_rdata_i == src_data_i);
  assign accept  = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  otp_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (timer_run),
    .last_o (timer_last)
  );

  otp_try_counter #(.MAX(MAX_TRIES)) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (try_clr),
    .inc_i   (try_inc),
    .limit_o (try_limit)
  );

  otp_addr_walk #(.AW(AW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (walk_load),
    .first_i   (first_addr_i),
    .last_i    (last_addr_i),
    .step_i    (walk_step),
    .rewind_i  (walk_rewind),
    .active_i  (busy_o),
    .cur_o     (cur_addr),
    .at_last_o (walk_at_last)
  );

  // next-state
  always_comb begin
    state_d     = state_q;
    lock_d      = lock_q;
    pass_d      = pass_q;
    fail_d      = fail_q;
    timer_run   = 1'b0;
    try_clr     = 1'b0;
    try_inc     = 1'b0;
    walk_load   = 1'b0;
    walk_step   = 1'b0;
    walk_rewind = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          walk_load = 1'b1;
          try_clr   = 1'b1;
          lock_d    = lock_i;
          pass_d    = 1'b0;
          fail_d    = 1'b0;
          state_d   = ST_PULSE;
        end
      end
      ST_PULSE: begin
        timer_run = 1'b1;
        if (timer_last) begin
          try_inc = 1'b1;
          state_d = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (byte_ok) begin
          if (walk_at_last) begin
            walk_rewind = 1'b1;
            state_d     = ST_CMP;
          end else begin
            walk_step = 1'b1;
            try_clr   = 1'b1;
            state_d   = ST_PULSE;
          end
        end else if (try_limit) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_PULSE;
        end
      end
      ST_CMP: begin
        if (!byte_ok) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end else if (walk_at_last) begin
          if (lock_q) begin
            state_d = ST_LOCK;
          end else begin
            pass_d  = 1'b1;
            state_d = ST_DONE;
          end
        end else begin
          walk_step = 1'b1;
        end
      end
      ST_LOCK: begin
        timer_run = 1'b1;
        if (timer_last) begin
          pass_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  // outputs decoded from state
  always_comb begin
    arr_addr_o  = cur_addr;
    arr_wdata_o = src_data_i;
    arr_wr_o    = 1'b0;
    arr_rd_o    = 1'b0;
    hv_en_o     = 1'b0;
    regsel_o    = 1'b0;
    rw_o        = 1'b1;
    unique case (state_q)
      ST_PULSE: begin
        arr_wr_o = 1'b1;
        hv_en_o  = 1'b1;
        rw_o     = 1'b0;
      end
      ST_VERIFY: begin
        arr_rd_o = 1'b1;
        hv_en_o  = 1'b1;
      end
      ST_CMP: begin
        arr_rd_o = 1'b1;
      end
      ST_LOCK: begin
        arr_addr_o  = PROT_ADDR;
        arr_wdata_o = '0;
        arr_wr_o    = 1'b1;
        hv_en_o     = 1'b1;
        regsel_o    = 1'b1;
        rw_o        = 1'b0;
      end
      default: ;
    endcase
  end

  assign src_addr_o = cur_addr;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;

  AST_WR_IS_HV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_o |-> hv_en_o && !rw_o && !arr_rd_o); // R3
  AST_RD_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_o |-> rw_o && !regsel_o); // R4
  AST_LOCK_AT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_o && regsel_o |-> arr_addr_o == PROT_ADDR); // R8
  AST_NO_PULSE_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !arr_wr_o); // R5
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_o)); // R9
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o); // R2
endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb_top;
  localparam int AW         = 12;
  localparam int DW         = 8;
  localparam int CLK_HZ     = 8000;
  localparam int PULSE_CYC  = CLK_HZ / 1000;
  localparam int MAX_TRIES  = 10;
  localparam int PROT       = 'h0E3F;
  localparam int DEPTH      = 1 << AW;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] first_a, last_a;
  logic          lock;
  logic [AW-1:0] src_addr, arr_addr;
  logic [DW-1:0] src_data, arr_wdata, arr_rdata;
  logic          arr_wr, arr_rd, hv_en, regsel, rw;
  logic          busy, done, pass, fail;

  logic [DW-1:0] srcmem [DEPTH];
  logic [DW-1:0] mem    [DEPTH];
  int            need   [DEPTH];
  int            pulses [DEPTH];
  bit            corrupt[DEPTH];
  int            exp_p  [DEPTH];

  int  prot_cnt, bad_mode, bad_width, wr_len;
  bit  wr_prev;
  int  checks, fails;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_data  = srcmem[src_addr];
  assign arr_rdata = (!hv_en && corrupt[arr_addr]) ? (mem[arr_addr] ^ 8'h01) : mem[arr_addr];

  otp_prog_seq #(.AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .MAX_TRIES(MAX_TRIES),
                 .PROT_ADDR(AW'(PROT))) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .first_addr_i(first_a),
    .last_addr_i(last_a), .lock_i(lock), .src_addr_o(src_addr),
    .src_data_i(src_data), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
    .arr_rdata_i(arr_rdata), .arr_wr_o(arr_wr), .arr_rd_o(arr_rd),
    .hv_en_o(hv_en), .regsel_o(regsel), .rw_o(rw), .busy_o(busy),
    .done_o(done), .pass_o(pass), .fail_o(fail)
  );

  // behavioural array model and port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_wr) begin
        wr_len = wr_len + 1;
        if (!hv_en || rw) bad_mode = bad_mode + 1;               // R3
        if (!wr_prev) begin
          if (regsel) begin
            if (int'(arr_addr) == PROT) prot_cnt = prot_cnt + 1;  // R8
            else bad_mode = bad_mode + 1;
          end else begin
            pulses[arr_addr] = pulses[arr_addr] + 1;
            if (pulses[arr_addr] >= need[arr_addr]) mem[arr_addr] = arr_wdata;
          end
        end
      end else begin
        if (wr_prev && wr_len != PULSE_CYC) bad_width = bad_width + 1;
        wr_len = 0;
      end
      if (arr_rd && (!rw || regsel)) bad_mode = bad_mode + 1;      // R4
      wr_prev = arr_wr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] src_fn(input int a);
    return DW'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic prep_array();
    for (int a = 0; a < DEPTH; a++) begin
      srcmem[a]  = src_fn(a);
      mem[a]     = ~src_fn(a);
      need[a]    = 1;
      pulses[a]  = 0;
      corrupt[a] = 1'b0;
      exp_p[a]   = 0;
    end
    prot_cnt  = 0;
    bad_mode  = 0;
    bad_width = 0;
  endtask

  // expected outcome derived from the requirements
  function automatic bit predict(input int f, input int l, input bit lk, output int exp_prot);
    bit ok = 1'b1;
    for (int a = f; a <= l; a++) begin
      if (need[a] > MAX_TRIES) begin   // R5
        exp_p[a] = MAX_TRIES;
        ok = 1'b0;
        break;
      end
      exp_p[a] = need[a];              // R4
    end
    if (ok) for (int a = f; a <= l; a++) if (corrupt[a]) ok = 1'b0;   // R6
    exp_prot = (ok && lk) ? 1 : 0;     // R8
    return ok;
  endfunction

  task automatic run_case(input int f, input int l, input bit lk, input bit poke_busy);
    int  exp_prot;
    bit  exp_pass;
    int  wd;
    int  bad_addr;
    exp_pass = predict(f, l, lk, exp_prot);
    @(negedge clk);
    start = 1'b1; first_a = AW'(f); last_a = AW'(l); lock = lk;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R2 busy after start", int'(busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; first_a = AW'(3000); last_a = AW'(3010); lock = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (done !== 1'b1 && wd < 40000) begin
      @(negedge clk);
      wd = wd + 1;
    end
    check(wd < 40000, "R2 watchdog", wd, 0);
    check(pass === exp_pass, "R7 pass flag", int'(pass), int'(exp_pass));
    check(fail === !exp_pass, "R5 R6 fail flag", int'(fail), int'(!exp_pass));
    bad_addr = -1;
    for (int a = 0; a < DEPTH; a++)
      if (pulses[a] != exp_p[a] && bad_addr < 0) bad_addr = a;
    check(bad_addr < 0, "R4 R5 pulses per address",
          (bad_addr < 0) ? 0 : pulses[bad_addr], (bad_addr < 0) ? 0 : exp_p[bad_addr]);
    check(prot_cnt == exp_prot, "R8 protection writes", prot_cnt, exp_prot);
    check(bad_width == 0, "R3 pulse width", bad_width, 0);
    check(bad_mode == 0, "R3 R4 mode encoding", bad_mode, 0);
    repeat (4) @(negedge clk);
    check(done === 1'b1 && pass === exp_pass && fail === !exp_pass && busy === 1'b0,
          "R9 result held", int'(pass), int'(exp_pass));
  endtask

  initial begin
    int unsigned seed_v;
    int f, l, bad;
    checks = 0; fails = 0;
    wr_prev = 1'b0; wr_len = 0;
    start = 1'b0; first_a = '0; last_a = '0; lock = 1'b0;
    seed_v = $urandom(32'h5EED_0A17);
    prep_array();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && pass === 0 && fail === 0 && arr_wr === 0
          && arr_rd === 0 && hv_en === 0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && arr_wr === 0 && hv_en === 0,
          "R1 idle after release", int'(arr_wr), 0);

    // directed: every byte sticks on its first pulse, no lock
    prep_array();
    run_case(0, 3, 1'b0, 1'b0);

    // directed: retries, lock, spurious start while busy ignored (R2)
    prep_array();
    for (int a = 10; a <= 15; a++) need[a] = 1 + (a % 9);
    run_case(10, 15, 1'b1, 1'b1);

    // boundary: exactly MAX_TRIES pulses still accepted (R5)
    prep_array();
    need[21] = MAX_TRIES;
    run_case(20, 23, 1'b1, 1'b0);

    // boundary: one more than the limit fails mid-window (R5)
    prep_array();
    need[31] = MAX_TRIES + 1;
    run_case(30, 34, 1'b1, 1'b0);

    // nominal-supply compare catches a weak byte (R6), no lock write (R8)
    prep_array();
    need[42] = 3;
    corrupt[43] = 1'b1;
    run_case(40, 45, 1'b1, 1'b0);

    // single-address window
    prep_array();
    need[100] = 4;
    run_case(100, 100, 1'b0, 1'b0);

    // random windows
    for (int n = 0; n < 6; n++) begin
      prep_array();
      f = int'($urandom_range(0, 200));
      l = f + int'($urandom_range(0, 15));
      for (int a = f; a <= l; a++) begin
        bad = int'($urandom_range(0, 39));
        need[a] = (bad == 0) ? MAX_TRIES + 1 : int'($urandom_range(1, MAX_TRIES));
        corrupt[a] = ($urandom_range(0, 59) == 0);
      end
      run_case(f, l, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule